// File: doc/BRIEF.md
# Interrupt Aggregation and Output Controller

This block gathers single-cycle event pulses from a set of internal sources (nine by default) into a sticky status register. It drives one external interrupt pin from the status bits whose enable bits are set. A status bit records its event whether or not its enable bit is set. The host clears a status bit by writing a one to it. A global enable bit gates the pin completely. The pin can signal by level or by a one-clock pulse, with either polarity.

The host uses a plain synchronous register port: one write strobe, an address, write data, and read data that follows the address combinationally. There are three registers:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Enable mask |
| 2 | Status |

Address 3 is unused. The pin is registered, so it reacts one clock after the status, enable or control state that causes the change.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, control, enable and status all read 0, and the pin is high (inactive for the active-low level default).
- R2: An event pulse on input bit i sets status bit i at the next clock edge even when enable bit i is 0, and the bit stays set with no further events.
- R3: Writing the status register (address 2) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event arrives in the same cycle as a write-1 clear of its bit, the bit ends up set, while the other cleared bits still clear.
- R5: While control bit 0 (global enable) is 0 the pin stays at its inactive level (the inverse of control bit 2), whatever status and enable hold. Writing control never changes the enable register.
- R6: With control bit 1 = 0 (level) and global enable set, the pin is active one clock after (status AND enable) becomes nonzero. It stays active while that holds, and returns to inactive one clock after it becomes zero.
- R7: With control bit 1 = 1 (edge) and global enable set, a rise of the gated (status AND enable) from zero to nonzero gives exactly one clock of active pin one clock later. Further events while it stays nonzero give no new pulse.
- R8: Control bit 2 sets polarity: 0 makes the active level low (falling pulse), 1 makes it high (rising pulse). The inactive level is the opposite.
- R9: Address 0 reads control in bits 2:0 with the upper bits reading 0. Address 1 reads the enable mask and address 2 reads status. Address 3 reads 0, and writes to it change nothing.
- R10: Event input i maps only to status bit i, for every source. Inputs 5, 6 and 7 carry the three waveform-channel end-of-program events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Single-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 enable, 2 status, 3 unused) |
| reg_wdata_i | input | N_SRC | Write data |
| reg_rdata_o | output | N_SRC | Read data for reg_addr_i |
| irq_pin_o | output | 1 | External interrupt pin |

## Verification
The assertions check four things on every cycle:
- Each event lands in status even against a simultaneous clear.
- Status bits fall only on a status write.
- The pin sits at its inactive level whenever the global enable was off.
- In level mode the pin tracks the gated pending set one clock late, and in edge mode a pulse never lasts two cycles.

The bench scenarios show what a single cycle cannot:
- The exact cycle a pulse starts, and that a second event into an already pending set starts none.
- Per-bit mapping across all sources.
- Read-back values of the register map.
- Control writes that leave the enable mask intact.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_ENABLE = 2'd1,
    A_STATUS = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  // Control register layout: bit 0 global gate, bit 1 edge mode, bit 2 polarity.
  typedef struct packed {
    logic pol_high;
    logic edge_md;
    logic gen;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Level the pin rests at when nothing is signalled.
  function automatic logic idle_level(ctrl_t c);
    return ~c.pol_high;
  endfunction

  // Registered pin value for the next cycle.
  function automatic logic pin_next(ctrl_t c, logic pend, logic pend_prev);
    logic act;
    act = c.edge_md ? (pend & ~pend_prev) : pend;
    act = act & c.gen;
    return c.pol_high ? act : ~act;
  endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [N_SRC-1:0]     wdata_i,
  input  logic [N_SRC-1:0]     status_i,
  output ctrl_t                ctrl_o,
  output logic [N_SRC-1:0]     enable_o,
  output logic [N_SRC-1:0]     clr_mask_o,
  output logic [N_SRC-1:0]     rdata_o
);
  localparam int unsigned PAD_W = N_SRC - CTRL_W;

  ctrl_t            ctrl_q;
  logic [N_SRC-1:0] enable_q;
  logic             wr_ctrl, wr_en, wr_stat;

  always_comb begin
    wr_ctrl = wr_i && (addr_i == A_CTRL);
    wr_en   = wr_i && (addr_i == A_ENABLE);
    wr_stat = wr_i && (addr_i == A_STATUS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      enable_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_en)   enable_q <= wdata_i;
    end
  end

  assign clr_mask_o = wr_stat ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      A_ENABLE: rdata_o = enable_q;
      A_STATUS: rdata_o = status_i;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (evt_i[g]) flag_q <= 1'b1;   // event wins over clear
      else if (clr_i[g]) flag_q <= 1'b0;
    end
    assign status_o[g] = flag_q;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_i,
  input  logic  pend_i,
  output logic  pend_rise_o,
  output logic  pin_o
);
  logic pend_prev_q;
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev_q <= 1'b0;
      pin_q       <= 1'b1;
    end else begin
      pend_prev_q <= pend_i;
      pin_q       <= pin_next(ctrl_i, pend_i, pend_prev_q);
    end
  end

  assign pend_rise_o = pend_i & ~pend_prev_q;
  assign pin_o       = pin_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              irq_pin_o
);
  ctrl_t            ctrl;
  logic [N_SRC-1:0] enable;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] clr_mask;
  logic             pend;
  logic             pend_rise;

  irq_reg_port #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .status_i(status), .ctrl_o(ctrl),
    .enable_o(enable), .clr_mask_o(clr_mask), .rdata_o(reg_rdata_o)
  );

  irq_status_bank #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_mask),
    .status_o(status)
  );

  assign pend = ctrl.gen & (|(status & enable));

  irq_pin_drv u_pin (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .pend_i(pend),
    .pend_rise_o(pend_rise), .pin_o(irq_pin_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] enable,
  input ctrl_t            ctrl,
  input logic             irq_pin_o
);
  logic stat_wr;
  assign stat_wr = reg_wr_i && (reg_addr_i == A_STATUS);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status & $past(evt_i)) == $past(evt_i)));                       // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status)));                     // R3

  AST_GATE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.gen |=> (irq_pin_o == !$past(ctrl.pol_high)));                           // R5

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.gen && !ctrl.edge_md) |=>
      (irq_pin_o == ($past(ctrl.pol_high) ? (|$past(status & enable))
                                          : !(|$past(status & enable)))));         // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.edge_md && $stable(ctrl) && irq_pin_o == ctrl.pol_high) |=>
      (irq_pin_o != $past(ctrl.pol_high)));                                        // R7
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .status(status), .enable(enable), .ctrl(ctrl),
  .irq_pin_o(irq_pin_o)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         wr = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         pin;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_pin_o(pin)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [N-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_reg(string req, logic [1:0] a, logic [N-1:0] exp);
    logic [N-1:0] d;
    rreg(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [N-1:0] m);
    evt = m;
    step();
    evt = '0;
  endtask

  task automatic chk_pin(string req, logic exp);
    chk(req, {{(N-1){1'b0}}, pin}, {{(N-1){1'b0}}, exp});
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl", 2'd0, '0);
    chk_reg("R1 enable", 2'd1, '0);
    chk_reg("R1 status", 2'd2, '0);
    chk_pin("R1 pin", 1'b1);
  endtask

  task automatic t_latch_masked;
    pulse(9'h020);
    step(3);
    chk_reg("R2 masked latch", 2'd2, 9'h020);
    chk_pin("R2 pin idle", 1'b1);
    wreg(2'd2, ALL);
    // R10 walking source check
    for (int i = 0; i < N; i++) begin
      pulse(9'h001 << i);
      chk_reg("R10 bit map", 2'd2, 9'h001 << i);
      wreg(2'd2, ALL);
    end
    pulse(ALL);
    chk_reg("R2 all sources", 2'd2, ALL);
  endtask

  task automatic t_clear;
    wreg(2'd2, 9'h0A0);
    chk_reg("R3 partial clear", 2'd2, 9'h15F);
    wreg(2'd2, 9'h000);
    chk_reg("R3 write zero", 2'd2, 9'h15F);
    wreg(2'd2, ALL);
    chk_reg("R3 full clear", 2'd2, 9'h000);
  endtask

  task automatic t_collide;
    pulse(9'h004);
    wr = 1'b1; addr = 2'd2; wdata = 9'h00C; evt = 9'h00C;
    evt = 9'h004;
    step();
    wr = 1'b0; wdata = '0; evt = '0;
    chk_reg("R4 event beats clear", 2'd2, 9'h004);
    pulse(9'h008);
    wr = 1'b1; addr = 2'd2; wdata = 9'h00C; evt = 9'h004;
    step();
    wr = 1'b0; wdata = '0; evt = '0;
    chk_reg("R4 other bit clears", 2'd2, 9'h004);
    wreg(2'd2, ALL);
  endtask

  task automatic t_global_off;
    wreg(2'd1, ALL);
    pulse(9'h040);
    step(2);
    chk_pin("R5 gated off low pol", 1'b1);
    wreg(2'd0, 9'h006);
    chk_reg("R5 enable kept", 2'd1, ALL);
    step();
    chk_pin("R5 gated off high pol", 1'b0);
    wreg(2'd0, 9'h000);
    wreg(2'd2, ALL);
    step();
  endtask

  task automatic t_level;
    wreg(2'd1, 9'h080);
    wreg(2'd0, 9'h001);
    pulse(9'h001);
    step();
    chk_pin("R6 masked source no irq", 1'b1);
    pulse(9'h080);
    chk_pin("R6 not yet", 1'b1);
    step();
    chk_pin("R6 active low", 1'b0);
    step(3);
    chk_pin("R6 held", 1'b0);
    wreg(2'd2, 9'h080);
    chk_pin("R6 one cycle late", 1'b0);
    step();
    chk_pin("R6 released", 1'b1);
    wreg(2'd0, 9'h005);
    pulse(9'h080);
    step();
    chk_pin("R8 level active high", 1'b1);
    wreg(2'd2, ALL);
    step();
    chk_pin("R8 level idle low", 1'b0);
  endtask

  task automatic t_edge;
    wreg(2'd0, 9'h003);
    step();
    chk_pin("R7 idle", 1'b1);
    pulse(9'h080);
    chk_pin("R7 before pulse", 1'b1);
    step();
    chk_pin("R7 pulse", 1'b0);
    step();
    chk_pin("R7 pulse ends", 1'b1);
    pulse(9'h080);
    step(2);
    chk_pin("R7 no repeat", 1'b1);
    wreg(2'd2, ALL);
    wreg(2'd0, 9'h007);
    step();
    chk_pin("R8 edge idle low", 1'b0);
    pulse(9'h080);
    step();
    chk_pin("R8 rising pulse", 1'b1);
    step();
    chk_pin("R8 rising pulse ends", 1'b0);
    wreg(2'd2, ALL);
    wreg(2'd0, 9'h000);
    step();
  endtask

  task automatic t_map;
    wreg(2'd1, 9'h0E0);
    wreg(2'd3, ALL);
    chk_reg("R9 spare reads zero", 2'd3, '0);
    chk_reg("R9 ctrl untouched", 2'd0, '0);
    chk_reg("R9 enable untouched", 2'd1, 9'h0E0);
    wreg(2'd0, 9'h1FA);
    chk_reg("R9 ctrl upper zero", 2'd0, 9'h002);
    wreg(2'd0, 9'h000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    t_reset();
    t_latch_masked();
    t_clear();
    t_collide();
    t_global_off();
    t_level();
    t_edge();
    t_map();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule